// File: doc/BRIEF.md
# Dual-Write Multi-Read Register File

This block is a register file that accepts two independent writes and serves several independent reads in every clock cycle. It is built only from storage arrays that have a single write port each, so it can map onto ordinary one-write memories. Write port A owns one full copy of the storage, and write port B owns a second full copy. Within each copy, every read port gets its own duplicate array that is driven by that port's own read address.

A one-bit-per-address steering table, built from flip-flops, records which of the two copies last received a write to each address. Every read port samples that bit together with both copies' data. A 2:1 selector then returns the value from the port that wrote most recently. No operation takes two clock edges, and no access is ever held off.

Reads are synchronous with one cycle of latency, and a read issued in the same cycle as a write to the same address sees the previous value. If both write ports hit one address in the same cycle, the value from port B is the one that survives. Reset points every address at copy A. It leaves the stored data alone.

Top module: `rf2w_regfile`

## Requirements
- R1: Two writes with their enables high, to different addresses in the same cycle, both take effect; each address later reads back the value written to it.
- R2: A read returns the value of the most recent write to that address, whichever port made it: a port A write after a port B write wins, and the reverse also holds.
- R3: When both write enables are high and both write addresses are equal, a later read of that address returns the port B data.
- R4: Read data appears on `rd_data` one clock edge after the read address is presented. A read issued in the same cycle as a write to the same address returns the value held before that write.
- R5: After a synchronous active-low reset, every address reads the value last written to it through port A, even if port B wrote it afterwards.
- R6: Each read port returns data for its own address, independently of the other read ports, in the same cycle. Read port p uses address bits [p*ADDR_W +: ADDR_W] and data bits [p*DATA_W +: DATA_W].
- R7: With both write enables low, no stored value and no steering bit changes, whatever the write address and data inputs hold.
- R8: Read ports that present the same address in the same cycle return identical data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; points every address at copy A |
| wr_en_a | input | 1 | Write enable, port A |
| wr_addr_a | input | ADDR_W | Write address, port A |
| wr_data_a | input | DATA_W | Write data, port A |
| wr_en_b | input | 1 | Write enable, port B (has priority on equal addresses) |
| wr_addr_b | input | ADDR_W | Write address, port B |
| wr_data_b | input | DATA_W | Write data, port B |
| rd_addr | input | N_RD*ADDR_W | Read addresses; port p in bits [p*ADDR_W +: ADDR_W] |
| rd_data | output | N_RD*DATA_W | Registered read data; port p in bits [p*DATA_W +: DATA_W] |

## Verification
A wrong steering bit does not show up as a garbled value. It shows up as a stale but plausible one: the next read of that address, one edge later, returns the other copy's contents. The bench therefore gives every write on port A a different value from every write on port B, and it makes sure both copies hold different values at each address before any readback. That way any misrouted selection, lost write or wrong collision priority is visible in the very next read cycle. The reset test relies on the same separation. After reset, each address should fall back to its port A value, which differs from the port B value it held before.

// File: rtl/rf2w_pkg.sv
// Shared definitions for the dual-write register file.
// Assumes: the steering bit is stored as a plain logic bit whose values
// match the encoding of src_e below (0 = copy A, 1 = copy B).
package rf2w_pkg;

    // Which storage copy holds the newest value for an address.
    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_e;

endpackage

// File: rtl/rf2w_bank.sv
// One single-write, single-read storage array with a registered read.
// Assumes: the read is registered, and a read of the address being written
// in the same cycle returns the old content (read-before-write).
// Contents have no reset and are undefined until written.
module rf2w_bank #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the incoming word when the write is enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Register the read; the non-blocking update gives read-before-write.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/rf2w_copy.sv
// Full storage copy owned by one write port.
// Holds one duplicate array per read port: every duplicate receives the same
// write, and each is read by its own read port's address.
// Assumes: read addresses and read data are packed with port p in slice p.
module rf2w_copy #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10,
    parameter int N_RD   = 3
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [N_RD*ADDR_W-1:0]   raddr,
    output logic [N_RD*DATA_W-1:0]   rdata
);

    // One duplicate array per read port.
    for (genvar p = 0; p < N_RD; p++) begin : g_dup
        rf2w_bank #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W)
        ) u_bank (
            .clk   (clk),
            .we    (we),
            .waddr (waddr),
            .wdata (wdata),
            .raddr (raddr[p*ADDR_W +: ADDR_W]),
            .rdata (rdata[p*DATA_W +: DATA_W])
        );
    end

endmodule

// File: rtl/rf2w_flags.sv
// Steering table: one bit per address, built from flip-flops, that records
// which write port touched the address most recently.
// It has two write ports and N_RD registered read ports. The read registers
// sample the table in the same cycle that the storage copies sample their
// arrays, so the selection and the data line up.
// Assumes: port B is applied after port A, so B wins on equal addresses.
// Reset is synchronous and active low, and points everything at copy A.
module rf2w_flags
    import rf2w_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int N_RD   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_a,
    input  logic [ADDR_W-1:0]      waddr_a,
    input  logic                   we_b,
    input  logic [ADDR_W-1:0]      waddr_b,
    input  logic [N_RD*ADDR_W-1:0] raddr,
    output logic [N_RD-1:0]        sel_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] flag_q;

    // Update the table; port B is written last so it wins on a collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            if (we_a) begin
                flag_q[waddr_a] <= SRC_A;
            end
            if (we_b) begin
                flag_q[waddr_b] <= SRC_B;
            end
        end
    end

    // Sample the pre-write steering bit for each read port.
    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_b[p] <= SRC_A;
            end else begin
                sel_b[p] <= flag_q[raddr[p*ADDR_W +: ADDR_W]];
            end
        end
    end

    // R2: a port B write leaves its address steered to copy B.
    p_flag_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we_b)) |-> (flag_q[$past(waddr_b)] == SRC_B));

    // R2: a port A write to an address that B does not also hit steers to copy A.
    p_flag_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we_a) &&
         !($past(we_b) && ($past(waddr_b) == $past(waddr_a))))
        |-> (flag_q[$past(waddr_a)] == SRC_A));

    // R3: on equal write addresses, port B owns the address afterwards.
    p_collide_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we_a) && $past(we_b) &&
         ($past(waddr_a) == $past(waddr_b)))
        |-> (flag_q[$past(waddr_a)] == SRC_B));

    // R5: the cycle after reset, every address points at copy A.
    p_reset_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (flag_q == '0));

    // R7: with both enables low, the table keeps its state.
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(we_a) && !$past(we_b)) |-> $stable(flag_q));

endmodule

// File: rtl/rf2w_rdsel.sv
// Per-read-port 2:1 output selector between the two storage copies.
// Assumes: the data and select inputs all come from registers that were
// clocked on the same edge, so this stage is pure logic.
module rf2w_rdsel #(
    parameter int DATA_W = 32,
    parameter int N_RD   = 3
) (
    input  logic [N_RD*DATA_W-1:0] data_a,
    input  logic [N_RD*DATA_W-1:0] data_b,
    input  logic [N_RD-1:0]        sel_b,
    output logic [N_RD*DATA_W-1:0] data_o
);

    for (genvar p = 0; p < N_RD; p++) begin : g_mux
        // Pick the copy named by this port's steering bit.
        always_comb begin
            data_o[p*DATA_W +: DATA_W] = sel_b[p] ? data_b[p*DATA_W +: DATA_W]
                                                  : data_a[p*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/rf2w_regfile.sv
// Register file with two write ports and N_RD read ports per cycle.
// Each write port owns a full storage copy. A flip-flop steering table picks
// the copy with the newest value for each read.
// Assumes: synchronous reads with one cycle of latency and read-before-write.
// Port B has priority on equal write addresses, but both copies are still
// written. Reset (synchronous, active low) only clears the steering table.
module rf2w_regfile #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10,
    parameter int N_RD   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_a,
    input  logic [ADDR_W-1:0]      wr_addr_a,
    input  logic [DATA_W-1:0]      wr_data_a,
    input  logic                   wr_en_b,
    input  logic [ADDR_W-1:0]      wr_addr_b,
    input  logic [DATA_W-1:0]      wr_data_b,
    input  logic [N_RD*ADDR_W-1:0] rd_addr,
    output logic [N_RD*DATA_W-1:0] rd_data
);
    localparam int RD_BUS_W = N_RD * DATA_W;

    logic [RD_BUS_W-1:0] copy_a_data;
    logic [RD_BUS_W-1:0] copy_b_data;
    logic [N_RD-1:0]     sel_b;

    // Storage copy written only by port A.
    rf2w_copy #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .N_RD   (N_RD)
    ) u_copy_a (
        .clk   (clk),
        .we    (wr_en_a),
        .waddr (wr_addr_a),
        .wdata (wr_data_a),
        .raddr (rd_addr),
        .rdata (copy_a_data)
    );

    // Storage copy written only by port B.
    rf2w_copy #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .N_RD   (N_RD)
    ) u_copy_b (
        .clk   (clk),
        .we    (wr_en_b),
        .waddr (wr_addr_b),
        .wdata (wr_data_b),
        .raddr (rd_addr),
        .rdata (copy_b_data)
    );

    // Last-writer steering table.
    rf2w_flags #(
        .ADDR_W (ADDR_W),
        .N_RD   (N_RD)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_a    (wr_en_a),
        .waddr_a (wr_addr_a),
        .we_b    (wr_en_b),
        .waddr_b (wr_addr_b),
        .raddr   (rd_addr),
        .sel_b   (sel_b)
    );

    // Output selection per read port.
    rf2w_rdsel #(
        .DATA_W (DATA_W),
        .N_RD   (N_RD)
    ) u_rdsel (
        .data_a (copy_a_data),
        .data_b (copy_b_data),
        .sel_b  (sel_b),
        .data_o (rd_data)
    );

endmodule

// File: tb/rf2w_regfile_test.sv
`timescale 1ns/1ps
module rf2w_regfile_test;
    localparam int AW    = 4;
    localparam int DW    = 16;
    localparam int NR    = 3;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n;
    logic           we_a, we_b;
    logic [AW-1:0]  wa_a, wa_b;
    logic [DW-1:0]  wd_a, wd_b;
    logic [NR*AW-1:0] rd_addr;
    logic [NR*DW-1:0] rd_data;

    int errs   = 0;
    int checks = 0;

    // Requirement-level model: last port A value and last value overall.
    logic [DW-1:0] m_a    [DEPTH];
    logic [DW-1:0] m_last [DEPTH];

    rf2w_regfile #(.DATA_W(DW), .ADDR_W(AW), .N_RD(NR)) uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en_a(we_a), .wr_addr_a(wa_a), .wr_data_a(wd_a),
        .wr_en_b(we_b), .wr_addr_b(wa_b), .wr_data_b(wd_b),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_rd(input int p, input int a);
        rd_addr[p*AW +: AW] = AW'(a);
    endtask

    function automatic logic [DW-1:0] port_out(input int p);
        return rd_data[p*DW +: DW];
    endfunction

    // Record in the model the writes presented this cycle; B is applied after A.
    task automatic model_wr();
        if (we_a) begin
            m_a[wa_a]    = wd_a;
            m_last[wa_a] = wd_a;
        end
        if (we_b) m_last[wa_b] = wd_b;
    endtask

    // Read every address on all ports (port p offset by 5*p) and compare.
    task automatic sweep(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            for (int p = 0; p < NR; p++) set_rd(p, (a + p*5) % DEPTH);
            @(negedge clk);
            for (int p = 0; p < NR; p++) check(req, port_out(p), m_last[(a + p*5) % DEPTH]);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; we_a = 1'b0; we_b = 1'b0;
        wa_a = '0; wa_b = '0; wd_a = '0; wd_b = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: dual writes to distinct addresses every cycle (A to a, B to a^8).
        for (int a = 0; a < DEPTH; a++) begin
            we_a = 1'b1; wa_a = AW'(a);       wd_a = DW'(16'hA000 + a*3);
            we_b = 1'b1; wa_b = AW'(a ^ 8);   wd_b = DW'(16'hB000 + a*7);
            @(negedge clk);
            model_wr();
        end
        we_a = 1'b0; we_b = 1'b0;
        // R1 R2 R6: readback on three ports with different addresses.
        sweep("R1/R2/R6");

        // R4: same-cycle write and read of address 3 returns the old value.
        we_a = 1'b1; wa_a = 4'd3; wd_a = 16'h3C3C;
        set_rd(0, 3);
        @(negedge clk);
        check("R4 read-before-write", port_out(0), m_last[3]);
        model_wr();
        we_a = 1'b0;
        @(negedge clk);
        check("R4 one-cycle latency", port_out(0), 16'h3C3C);

        // R2: B then A to address 5, A must win; A then B to 6, B must win.
        we_b = 1'b1; wa_b = 4'd5; wd_b = 16'h5B5B;
        @(negedge clk); model_wr();
        we_b = 1'b0; we_a = 1'b1; wa_a = 4'd5; wd_a = 16'h5A5A;
        @(negedge clk); model_wr();
        wa_a = 4'd6; wd_a = 16'h6A6A;
        @(negedge clk); model_wr();
        we_a = 1'b0; we_b = 1'b1; wa_b = 4'd6; wd_b = 16'h6B6B;
        @(negedge clk); model_wr();
        we_b = 1'b0;
        set_rd(0, 5); set_rd(1, 6);
        @(negedge clk);
        check("R2 A after B", port_out(0), 16'h5A5A);
        check("R2 B after A", port_out(1), 16'h6B6B);

        // R3: collisions on every even address; R8: all ports on one address.
        for (int a = 0; a < DEPTH; a += 2) begin
            we_a = 1'b1; wa_a = AW'(a); wd_a = DW'(16'h1100 + a);
            we_b = 1'b1; wa_b = AW'(a); wd_b = DW'(16'h2200 + a);
            set_rd(0, a);
            @(negedge clk);
            check("R4 collision read-before-write", port_out(0), m_last[a]);
            model_wr();
            we_a = 1'b0; we_b = 1'b0;
            for (int p = 0; p < NR; p++) set_rd(p, a);
            @(negedge clk);
            check("R3 port B wins", port_out(0), DW'(16'h2200 + a));
            for (int p = 1; p < NR; p++) check("R8 same address", port_out(p), port_out(0));
        end

        // R7: enables low with busy address/data inputs change nothing.
        for (int c = 0; c < 6; c++) begin
            wa_a = AW'(c); wd_a = 16'hDEAD; wa_b = AW'(c + 1); wd_b = 16'hBEEF;
            @(negedge clk);
        end
        sweep("R7");

        // R5: reset steers every address back to its last port A value.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < DEPTH; a++) m_last[a] = m_a[a];
        sweep("R5");

        // R2: steering works again after reset.
        we_b = 1'b1; wa_b = 4'd9; wd_b = 16'h9B9B;
        @(negedge clk); model_wr();
        we_b = 1'b0; set_rd(2, 9);
        @(negedge clk);
        check("R2 after reset", port_out(2), 16'h9B9B);

        finish_run();
    end

endmodule